// File: doc/BRIEF.md
# Low-Power Mode Clock Gating Controller

This block decides, cycle by cycle, which clocks of a small microcontroller may run. The CPU writes four low-power control bits: halt execution, stop the main oscillator, stop the sub-main peripheral clock and stop the low-frequency auxiliary clock. The block turns those bits into four clock enables and a CPU-halted flag. The real oscillators and glitch-free gate cells sit outside and consume the enables. The combinations of bits form the usual power levels: halt alone, halt plus oscillator off, halt plus sub-clock off, halt plus both, and all four bits set.

When the interrupt logic accepts an interrupt, the block saves the live bits in a one-entry register, clears them, and forces every clock on. At the return from interrupt it reloads the saved bits, so the previous power level resumes. If the handler raised a clear-on-exit request, it leaves all bits zero instead, and the part stays active. While a debugger is attached, the main oscillator and the CPU clock stay on, but the peripheral clocks still obey their bits. Asynchronous wake-up pins pass through a two-flop synchronizer, which turns them into interrupt requests.

Top module: `lpc_clock_ctrl`

## Requirements
- R1: After a synchronous active-low reset, the live bits are 0000, all four clock enables are 1, the halted flag is 0 and all wake requests are 0.
- R2: A write strobe loads the live bits on the rising edge that samples it. Bit encoding: bit0 halts the CPU, bit1 stops the main oscillator, bit2 stops the sub-main clock, bit3 stops the auxiliary clock.
- R3: Without debug and outside interrupt service, the main oscillator enable is the inverse of bit1. The CPU clock enable is 1 only when both bit0 and bit1 are 0. The sub-main enable is the inverse of bit2 and the auxiliary enable is the inverse of bit3.
- R4: With debug enabled, the main oscillator and CPU clock enables are 1 in every power level, while the sub-main and auxiliary enables still follow bit2 and bit3.
- R5: An accepted interrupt outside service copies the live bits into the save register and clears the live bits on the same edge. All enables become 1 and the halted flag drops after that edge.
- R6: A return strobe during service without a clear-on-exit request reloads the saved bits and ends service.
- R7: A clear-on-exit strobe during service makes the next return leave the live bits at 0000.
- R8: An interrupt accept during service, and a return outside service, have no effect. A write in the same cycle as an honored accept or return is dropped.
- R9: The halted flag is 1 exactly when bit0 is set and no interrupt is in service.
- R10: Clock enables change only on the falling clock edge. Half a period after the rising edge that changes the bits, the old enables are still visible.
- R11: Each wake request equals its asynchronous input delayed by two rising edges.
- R12: With peripheral gating disabled by parameter, the sub-main and auxiliary enables stay 1 whatever the bits.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Free-running main clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dbg_en | input | 1 | Debugger attached; keeps the main oscillator and CPU clock alive |
| mode_wr | input | 1 | Write strobe for the live low-power bits |
| mode_wdata | input | 4 | New low-power bits |
| irq_take | input | 1 | Interrupt accept strobe |
| irq_ret | input | 1 | Return-from-interrupt strobe |
| exit_clr | input | 1 | Clear-on-exit request issued by the handler |
| wake_async | input | N_WAKE | Asynchronous wake-up pins |
| lp_bits | output | 4 | Live low-power bits |
| osc_en | output | 1 | Main oscillator enable |
| cpu_clk_en | output | 1 | CPU clock enable |
| sub_clk_en | output | 1 | Sub-main peripheral clock enable |
| aux_clk_en | output | 1 | Auxiliary low-frequency clock enable |
| cpu_halted | output | 1 | Instruction execution stopped |
| wake_irq | output | N_WAKE | Synchronized wake-up interrupt requests |

## Verification
The hardest state to reach from the ports is a stacked sequence. The part sits in a power level, an interrupt is accepted, a second accept arrives while the first is still in service, and the handler may or may not raise clear-on-exit before returning. Only the bits after the return show whether the one-entry save survived. The stimulus walks through each of these orders on purpose, including a write that collides with an accept. It then runs a long pseudo-random phase where writes, accepts, returns, clear requests, debug and wake pins overlap freely. Every clock cycle, a behavioural model checks the result both before and after the falling edge.

// File: rtl/lpc_pkg.sv
// Shared definitions for the low-power clock controller.
// Assumes a 4-bit low-power field whose bit positions are fixed below.
package lpc_pkg;
    localparam int LP_W     = 4;
    localparam int BIT_HALT = 0;   // stop instruction execution
    localparam int BIT_OSC  = 1;   // stop main oscillator
    localparam int BIT_SUB  = 2;   // stop sub-main clock
    localparam int BIT_AUX  = 3;   // stop auxiliary clock

    typedef logic [LP_W-1:0] lp_bits_t;

    // Enable vector, one bit per gated clock.
    typedef struct packed {
        logic aux;
        logic sub;
        logic cpu;
        logic osc;
    } clk_en_t;

    localparam int EN_W = $bits(clk_en_t);
endpackage

// File: rtl/lpc_mode_state.sv
// Holds the live low-power bits, the one-entry save register, the
// in-service flag and the clear-on-exit flag.
// Assumes accept/return strobes are single-cycle and synchronous to clk.
// Priority: honored accept, then honored return, then write.
module lpc_mode_state
    import lpc_pkg::*;
(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     wr_en,
    input  lp_bits_t wr_bits,
    input  logic     take,
    input  logic     ret,
    input  logic     clr_req,
    output lp_bits_t bits_q,
    output lp_bits_t saved_q,
    output logic     svc_q,
    output logic     clr_q
);
    logic take_ok;
    logic ret_ok;

    assign take_ok = take && !svc_q;
    assign ret_ok  = ret && svc_q;

    // Live bits: cleared on accept, reloaded on return, else written.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            bits_q <= '0;
        end else if (take_ok) begin
            bits_q <= '0;
        end else if (ret_ok) begin
            bits_q <= clr_q ? lp_bits_t'('0) : saved_q;
        end else if (wr_en) begin
            bits_q <= wr_bits;
        end
    end

    // Save register: captures the live bits on an honored accept only.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            saved_q <= '0;
        end else if (take_ok) begin
            saved_q <= bits_q;
        end
    end

    // Service flag and clear-on-exit flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            svc_q <= 1'b0;
            clr_q <= 1'b0;
        end else if (take_ok) begin
            svc_q <= 1'b1;
            clr_q <= 1'b0;
        end else if (ret_ok) begin
            svc_q <= 1'b0;
            clr_q <= 1'b0;
        end else if (svc_q && clr_req) begin
            clr_q <= 1'b1;
        end
    end
endmodule

// File: rtl/lpc_gate_stage.sv
// Turns the live bits into clock enables and registers them on the
// falling clock edge so that a downstream gate never sees a glitch.
// Assumes the bits change only on rising edges.
module lpc_gate_stage
    import lpc_pkg::*;
#(
    parameter bit GATE_SLOW = 1'b1
)(
    input  logic     clk,
    input  logic     rst_n,
    input  logic     dbg_en,
    input  logic     svc,
    input  lp_bits_t bits,
    output clk_en_t  en_q
);
    clk_en_t req;
    logic    keep_fast;

    assign keep_fast = svc || dbg_en;

    // Fast clocks: oscillator and CPU clock, kept alive by debug or service.
    always_comb begin
        req.osc = keep_fast || !bits[BIT_OSC];
        req.cpu = req.osc && (keep_fast || !bits[BIT_HALT]);
    end

    // Slow clocks: gating is present only when the parameter asks for it.
    generate
        if (GATE_SLOW) begin : g_slow_gate
            always_comb begin
                req.sub = svc || !bits[BIT_SUB];
                req.aux = svc || !bits[BIT_AUX];
            end
        end else begin : g_slow_free
            always_comb begin
                req.sub = 1'b1;
                req.aux = 1'b1;
            end
        end
    endgenerate

    // One falling-edge flop per enable.
    genvar gi;
    generate
        for (gi = 0; gi < EN_W; gi++) begin : g_en_reg
            logic [EN_W-1:0] req_v;
            logic            q;
            assign req_v = req;
            always_ff @(negedge clk) begin
                if (!rst_n) q <= 1'b1;
                else        q <= req_v[gi];
            end
        end
    endgenerate

    // Gather the flops back into the enable struct.
    always_comb begin
        en_q.osc = g_en_reg[0].q;
        en_q.cpu = g_en_reg[1].q;
        en_q.sub = g_en_reg[2].q;
        en_q.aux = g_en_reg[3].q;
    end
endmodule

// File: rtl/lpc_wake_sync.sv
// Synchronizer chain for asynchronous wake-up pins; the last stage is the
// interrupt request. Assumes pins are level signals wider than one clock.
module lpc_wake_sync #(
    parameter int N_WAKE = 2,
    parameter int STAGES = 2
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic [N_WAKE-1:0] pin,
    output logic [N_WAKE-1:0] req
);
    localparam int LAST = STAGES - 1;

    genvar gw;
    generate
        for (gw = 0; gw < N_WAKE; gw++) begin : g_pin
            logic [STAGES-1:0] chain;
            // Shift the pin through the chain, reset to zero.
            always_ff @(posedge clk) begin
                if (!rst_n) chain <= '0;
                else        chain <= {chain[STAGES-2:0], pin[gw]};
            end
            assign req[gw] = chain[LAST];
        end
    endgenerate
endmodule

// File: rtl/lpc_clock_ctrl.sv
// Top of the low-power clock controller: mode state, enable stage and
// wake-up synchronizers. Assumes a single free-running clock; the gated
// clocks themselves are built outside from the enables.
module lpc_clock_ctrl
    import lpc_pkg::*;
#(
    parameter int N_WAKE     = 2,
    parameter int SYNC_DEPTH = 2,
    parameter bit GATE_SLOW  = 1'b1
)(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dbg_en,
    input  logic              mode_wr,
    input  logic [LP_W-1:0]   mode_wdata,
    input  logic              irq_take,
    input  logic              irq_ret,
    input  logic              exit_clr,
    input  logic [N_WAKE-1:0] wake_async,
    output logic [LP_W-1:0]   lp_bits,
    output logic              osc_en,
    output logic              cpu_clk_en,
    output logic              sub_clk_en,
    output logic              aux_clk_en,
    output logic              cpu_halted,
    output logic [N_WAKE-1:0] wake_irq
);
    lp_bits_t bits_q;
    lp_bits_t saved_q;
    logic     svc_q;
    logic     clr_q;
    clk_en_t  en_q;

    lpc_mode_state u_state (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (mode_wr),
        .wr_bits (mode_wdata),
        .take    (irq_take),
        .ret     (irq_ret),
        .clr_req (exit_clr),
        .bits_q  (bits_q),
        .saved_q (saved_q),
        .svc_q   (svc_q),
        .clr_q   (clr_q)
    );

    lpc_gate_stage #(.GATE_SLOW(GATE_SLOW)) u_gate (
        .clk    (clk),
        .rst_n  (rst_n),
        .dbg_en (dbg_en),
        .svc    (svc_q),
        .bits   (bits_q),
        .en_q   (en_q)
    );

    lpc_wake_sync #(.N_WAKE(N_WAKE), .STAGES(SYNC_DEPTH)) u_wake (
        .clk   (clk),
        .rst_n (rst_n),
        .pin   (wake_async),
        .req   (wake_irq)
    );

    // Drive the outputs from state and enable registers.
    assign lp_bits    = bits_q;
    assign osc_en     = en_q.osc;
    assign cpu_clk_en = en_q.cpu;
    assign sub_clk_en = en_q.sub;
    assign aux_clk_en = en_q.aux;
    assign cpu_halted = bits_q[BIT_HALT] && !svc_q;
endmodule

// File: rtl/lpc_clock_ctrl_chk.sv
// Property checker for lpc_clock_ctrl, attached by bind below.
// Assumes inputs change away from the rising clock edge.
module lpc_clock_ctrl_chk #(
    parameter int N_WAKE    = 2,
    parameter bit GATE_SLOW = 1'b1
)(
    input logic              clk,
    input logic              rst_n,
    input logic              dbg_en,
    input logic              mode_wr,
    input logic              irq_take,
    input logic              irq_ret,
    input logic [3:0]        lp_bits,
    input logic              osc_en,
    input logic              cpu_clk_en,
    input logic              sub_clk_en,
    input logic              aux_clk_en,
    input logic              cpu_halted,
    input logic [N_WAKE-1:0] wake_async,
    input logic [N_WAKE-1:0] wake_irq,
    input logic [3:0]        saved,
    input logic              svc,
    input logic              clr
);
    assert_take_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_take && !svc) |=> (lp_bits == 4'b0000 && svc && !cpu_halted));

    assert_ret_restore_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && svc && !clr) |=> (lp_bits == $past(saved) && !svc));

    assert_clear_exit_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && svc && clr) |=> (lp_bits == 4'b0000 && !svc));

    assert_idle_ret_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (irq_ret && !svc && !irq_take && !mode_wr) |=> $stable(lp_bits));

    assert_dbg_keeps_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (dbg_en && $past(dbg_en)) |-> (osc_en && cpu_clk_en));

    genvar gk;
    generate
        for (gk = 0; gk < N_WAKE; gk++) begin : g_wk
            assert_wake_delay_R11: assert property (@(posedge clk) disable iff (!rst_n)
                $rose(wake_irq[gk]) |-> $past(wake_async[gk], 2));
        end
        if (!GATE_SLOW) begin : g_free
            assert_slow_free_R12: assert property (@(posedge clk) disable iff (!rst_n)
                (sub_clk_en && aux_clk_en));
        end
    endgenerate
endmodule

bind lpc_clock_ctrl lpc_clock_ctrl_chk #(.N_WAKE(N_WAKE), .GATE_SLOW(GATE_SLOW)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .dbg_en     (dbg_en),
    .mode_wr    (mode_wr),
    .irq_take   (irq_take),
    .irq_ret    (irq_ret),
    .lp_bits    (lp_bits),
    .osc_en     (osc_en),
    .cpu_clk_en (cpu_clk_en),
    .sub_clk_en (sub_clk_en),
    .aux_clk_en (aux_clk_en),
    .cpu_halted (cpu_halted),
    .wake_async (wake_async),
    .wake_irq   (wake_irq),
    .saved      (saved_q),
    .svc        (svc_q),
    .clr        (clr_q)
);

// File: tb/tb_lpc_clock_ctrl.sv
`timescale 1ns/100ps
// Bench for lpc_clock_ctrl: behavioural reference model compared every
// cycle, plus directed sequences and a pseudo-random phase.
module tb_lpc_clock_ctrl;
    localparam int NW = 2;

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic          rst_n = 1'b0;
    logic          dbg_en = 1'b0;
    logic          mode_wr = 1'b0;
    logic [3:0]    mode_wdata = 4'h0;
    logic          irq_take = 1'b0;
    logic          irq_ret = 1'b0;
    logic          exit_clr = 1'b0;
    logic [NW-1:0] wake_async = '0;

    logic [3:0]    lp_bits, lp_bits_n;
    logic          osc_en, cpu_clk_en, sub_clk_en, aux_clk_en, cpu_halted;
    logic          osc_n, cpu_n, sub_n, aux_n, halted_n;
    logic [NW-1:0] wake_irq, wake_irq_n;

    lpc_clock_ctrl #(.N_WAKE(NW)) dut (
        .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .irq_take(irq_take), .irq_ret(irq_ret),
        .exit_clr(exit_clr), .wake_async(wake_async), .lp_bits(lp_bits),
        .osc_en(osc_en), .cpu_clk_en(cpu_clk_en), .sub_clk_en(sub_clk_en),
        .aux_clk_en(aux_clk_en), .cpu_halted(cpu_halted), .wake_irq(wake_irq)
    );

    lpc_clock_ctrl #(.N_WAKE(NW), .GATE_SLOW(1'b0)) dut_ng (
        .clk(clk), .rst_n(rst_n), .dbg_en(dbg_en), .mode_wr(mode_wr),
        .mode_wdata(mode_wdata), .irq_take(irq_take), .irq_ret(irq_ret),
        .exit_clr(exit_clr), .wake_async(wake_async), .lp_bits(lp_bits_n),
        .osc_en(osc_n), .cpu_clk_en(cpu_n), .sub_clk_en(sub_n),
        .aux_clk_en(aux_n), .cpu_halted(halted_n), .wake_irq(wake_irq_n)
    );

    int checks = 0;
    int errors = 0;
    bit armed  = 1'b0;
    bit ended  = 1'b0;

    task automatic check(string tag, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    // Reference model state.
    logic [3:0]    m_bits = 4'h0, m_save = 4'h0;
    bit            m_isr = 1'b0, m_clr = 1'b0;
    logic [NW-1:0] m_w1 = '0, m_w2 = '0;
    logic [3:0]    e_prev = 4'hF;

    // Expected enables as {aux, sub, cpu, osc}.
    function automatic logic [3:0] exp_en(bit gate);
        logic o, c, s, a;
        if (!rst_n) return 4'hF;
        o = m_isr | dbg_en | ~m_bits[1];
        c = o & (m_isr | dbg_en | ~m_bits[0]);
        s = m_isr | ~(gate & m_bits[2]);
        a = m_isr | ~(gate & m_bits[3]);
        return {a, s, c, o};
    endfunction

    // Model update on each rising edge from the sampled inputs.
    always @(posedge clk) begin
        if (!rst_n) begin
            m_bits = 4'h0; m_save = 4'h0; m_isr = 1'b0; m_clr = 1'b0;
            m_w1 = '0; m_w2 = '0;
        end else begin
            m_w2 = m_w1;
            m_w1 = wake_async;
            if (irq_take && !m_isr) begin
                m_save = m_bits; m_bits = 4'h0; m_isr = 1'b1; m_clr = 1'b0;
            end else if (irq_ret && m_isr) begin
                m_bits = m_clr ? 4'h0 : m_save; m_isr = 1'b0; m_clr = 1'b0;
            end else begin
                if (mode_wr) m_bits = mode_wdata;
                if (m_isr && exit_clr) m_clr = 1'b1;
            end
        end
    end

    // Per-cycle comparison before and after the falling edge.
    always @(posedge clk) begin
        if (armed) begin
            logic [3:0] e_now;
            #0.5;
            check("R10 enables before falling edge",
                  {aux_clk_en, sub_clk_en, cpu_clk_en, osc_en}, e_prev);
            #3;
            e_now = exp_en(1'b1);
            check(dbg_en ? "R4 enables" : "R3 enables",
                  {aux_clk_en, sub_clk_en, cpu_clk_en, osc_en}, e_now);
            check("R2 live bits", lp_bits, m_bits);
            check("R9 halted", cpu_halted, m_bits[0] & ~m_isr);
            check("R11 wake requests", wake_irq, m_w2);
            check("R12 ungated enables", {aux_n, sub_n, cpu_n, osc_n}, exp_en(1'b0));
            e_prev = e_now;
        end
    end

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic do_write(logic [3:0] b);
        mode_wr = 1'b1; mode_wdata = b;
        step();
        mode_wr = 1'b0;
    endtask

    task automatic do_take();
        irq_take = 1'b1; step(); irq_take = 1'b0;
    endtask

    task automatic do_ret();
        irq_ret = 1'b1; step(); irq_ret = 1'b0;
    endtask

    task automatic do_clr();
        exit_clr = 1'b1; step(); exit_clr = 1'b0;
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        #(200000 * 5);
        errors++;
        $display("FAIL watchdog expired actual=%0d expected=%0d", 1, 0);
        finish_run();
    end

    initial begin
        logic [15:0] lfsr;
        step(); step();
        armed = 1'b1;
        step(); step();
        rst_n = 1'b1;
        step();
        #2.5;
        check("R1 reset bits", lp_bits, 0);
        check("R1 reset enables", {aux_clk_en, sub_clk_en, cpu_clk_en, osc_en}, 15);
        check("R1 reset halted", cpu_halted, 0);
        check("R1 reset wake", wake_irq, 0);

        do_write(4'b0001);
        #2.5;
        check("R2 halt level bits", lp_bits, 1);
        check("R9 halted in halt level", cpu_halted, 1);
        check("R3 cpu clock off, osc on", {cpu_clk_en, osc_en}, 1);

        do_write(4'b1111);
        #2.5;
        check("R3 deepest level enables", {aux_clk_en, sub_clk_en, cpu_clk_en, osc_en}, 0);
        dbg_en = 1'b1;
        step();
        #2.5;
        check("R4 debug keeps fast clocks", {aux_clk_en, sub_clk_en, cpu_clk_en, osc_en}, 3);
        dbg_en = 1'b0;
        step();

        do_write(4'b0000);
        check("R10 old osc enable half cycle before", osc_en, 0);
        #2.5;
        check("R10 new osc enable after falling edge", osc_en, 1);

        do_write(4'b0111);
        do_take();
        #2.5;
        check("R5 bits cleared on accept", lp_bits, 0);
        check("R5 all enables on", {aux_clk_en, sub_clk_en, cpu_clk_en, osc_en}, 15);
        check("R5 halted drops", cpu_halted, 0);
        do_take();
        do_ret();
        #2.5;
        check("R8 second accept kept first save", lp_bits, 7);
        check("R6 level resumed after return", lp_bits, 7);

        do_take();
        do_clr();
        do_ret();
        #2.5;
        check("R7 clear-on-exit leaves active", lp_bits, 0);

        do_write(4'b0101);
        do_ret();
        #2.5;
        check("R8 return outside service ignored", lp_bits, 5);

        mode_wr = 1'b1; mode_wdata = 4'b1111; irq_take = 1'b1;
        step();
        mode_wr = 1'b0; irq_take = 1'b0;
        #2.5;
        check("R8 write dropped on accept", lp_bits, 0);
        do_ret();
        #2.5;
        check("R6 saved level reloaded", lp_bits, 5);

        wake_async[0] = 1'b1;
        step();
        #2.5;
        check("R11 wake after one edge", wake_irq, 0);
        step();
        #2.5;
        check("R11 wake after two edges", wake_irq, 1);
        wake_async[0] = 1'b0;

        do_write(4'b1111);
        #2.5;
        check("R12 ungated slow clocks stay on", {aux_n, sub_n}, 3);
        check("R12 ungated osc still stops", osc_n, 0);

        lfsr = 16'hACE1;
        for (int i = 0; i < 400; i++) begin
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            mode_wr    = lfsr[0] & lfsr[1];
            mode_wdata = lfsr[7:4];
            irq_take   = (lfsr[3:2] == 2'b11) & lfsr[8];
            irq_ret    = (lfsr[10:9] == 2'b11);
            exit_clr   = lfsr[11] & lfsr[12];
            dbg_en     = (lfsr[15:13] == 3'b111);
            wake_async = lfsr[14:13];
            step();
        end
        mode_wr = 1'b0; irq_take = 1'b0; irq_ret = 1'b0; exit_clr = 1'b0;
        step(); step();
        finish_run();
    end
endmodule